// File: doc/BRIEF.md
# Tuner Synthesiser I2C Control Slave

This block is the serial control port of a frequency synthesiser for tuners. It is an I2C slave that runs from the system clock. It samples SCL and SDA through synchronisers and pulls SDA low through an open-drain enable. Two bits of its 7-bit device address come from strap inputs, so up to four such synthesisers can share one bus.

In a write transfer, each data byte after the address is classified by its first (most significant) bit:
- A byte starting with 0 opens a frequency pair, which programs the 15-bit divider ratio.
- A byte starting with 1 opens a control pair. The first byte of this pair holds the charge-pump and test bits, and its partner sets the output port enables.

Pairs may follow one another until a stop. Registers change only on complete bytes. The ratio changes only when a whole pair has arrived.

In a read transfer the slave returns a status byte. The byte holds a sticky power-on flag and the live lock input. The slave repeats it for as long as the master acknowledges.

Top module: `tuner_i2c_ctl`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1100_0, `addr_sel[1]`, `addr_sel[0]`, sent MSB first. Bit 0 selects read (1) or write (0). A mismatching address gets no acknowledge, and the rest of that transfer leaves every register unchanged.
- R2: In a write transfer, every complete data byte is acknowledged by pulling SDA low in the ninth clock.
- R3: A pair-opening byte with bit 7 = 0 stores its bits 6..0 as ratio bits 14..8. The next byte supplies ratio bits 7..0. `ratio` updates in one step only after that second byte is complete.
- R4: A pair-opening byte with bit 7 = 1 sets these outputs: `cp_high` from bit 6, `test_en` from bit 5, `cp_off` from bit 4 and `drv_off` from bit 0.
- R5: The byte after a control byte sets `port_on` as follows: P7 from bit 7, P4 from bit 4, P2 from bit 2, P1 from bit 1 and P0 from bit 0. The packed order of `port_on` is {P7,P4,P2,P1,P0}, and 1 means the port is on.
- R6: Further pairs in the same transfer are decoded without re-addressing. Each start or stop makes the next data byte a pair opener, and a stop returns the slave to idle with SDA released.
- R7: A byte cut off by a stop, even after seven bits, changes no register. A frequency pair whose second byte never arrives leaves `ratio` unchanged.
- R8: A read returns the status byte MSB first: bit 7 is the power-on flag, bit 6 is `lock_i` (1 = locked), and bits 5..0 are 0.
- R9: After each status byte the slave releases SDA. If the master acknowledges, another status byte follows. If it does not, the slave stays off the bus until the next start.
- R10: The power-on flag is 1 after reset. It is cleared only by a stop that ends a read transfer, and a write ending in stop leaves it set.
- R11: After reset `ratio`, the control bits and `port_on` are 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | I2C clock from the bus |
| sda_i | input | 1 | I2C data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 2 | Strapped low address bits |
| lock_i | input | 1 | Phase-lock indication, 1 = locked |
| ratio | output | 15 | Divider ratio |
| cp_high | output | 1 | Charge-pump high current |
| test_en | output | 1 | Phase-comparator test routing |
| cp_off | output | 1 | Charge-pump disable |
| drv_off | output | 1 | Tuning-drive output disable |
| port_on | output | 5 | Port enables {P7,P4,P2,P1,P0} |

## Verification
The assertions take for granted a well-formed bus. SDA changes only while SCL is low, except at starts and stops. Each SCL level lasts several system clocks, so every edge passes the synchronisers as one clean event. The master in the bench holds each SCL phase for at least eight clocks and moves SDA mid-low-phase. Its only deliberate breaks of byte framing are stops placed after five or seven bits, which is exactly what R7 describes.

// File: rtl/tuner_i2c_ctl.sv
module tuner_i2c_ctl #(
  parameter logic [4:0] DEV_ID = 5'b11000,
  parameter int         SYNC   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  input  logic        lock_i,
  output logic [14:0] ratio,
  output logic        cp_high,
  output logic        test_en,
  output logic        cp_off,
  output logic        drv_off,
  output logic [4:0]  port_on
);
  localparam int SW = SYNC + 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_MACK} st_t;

  logic [SW-1:0] scl_s, sda_s;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[SW-2:0], scl_i};
      sda_s <= {sda_s[SW-2:0], sda_i};
    end

  wire scl_hi   = scl_s[SW-2];
  wire sda_now  = sda_s[SW-2];
  wire scl_rise = scl_hi & ~scl_s[SW-1];
  wire scl_fall = ~scl_hi & scl_s[SW-1];
  wire both_hi  = scl_hi & scl_s[SW-1];
  wire start_det = both_hi & ~sda_now & sda_s[SW-1];
  wire stop_det  = both_hi & sda_now & ~sda_s[SW-1];

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, tx;
  logic       rw, m_ack, pair2, pair_ctl, por, rd_seen;
  logic [6:0] hi_pend;

  wire [7:0] status    = {por, lock_i, 6'b0};
  wire       wr_commit = (st == S_WR) && scl_fall && (cnt == 4'd8) && !stop_det && !start_det;
  wire       addr_hit  = (sr[7:1] == {DEV_ID, addr_sel});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sr       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      m_ack    <= 1'b0;
      pair2    <= 1'b0;
      pair_ctl <= 1'b0;
      hi_pend  <= '0;
      por      <= 1'b1;
      rd_seen  <= 1'b0;
      sda_oe   <= 1'b0;
      ratio    <= '0;
      cp_high  <= 1'b0;
      test_en  <= 1'b0;
      cp_off   <= 1'b0;
      drv_off  <= 1'b0;
      port_on  <= '0;
    end else if (stop_det) begin
      st      <= S_IDLE;
      sda_oe  <= 1'b0;
      pair2   <= 1'b0;
      rd_seen <= 1'b0;
      if (rd_seen) por <= 1'b0;
    end else if (start_det) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
      pair2  <= 1'b0;
    end else begin
      case (st)
        S_ADDR:
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_now};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              rw     <= sr[0];
              st     <= S_AACK;
            end else begin
              st <= S_IDLE;
            end
          end
        S_AACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx      <= status;
              sda_oe  <= ~status[7];
              rd_seen <= 1'b1;
              st      <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
        S_WR:
          if (scl_rise) begin
            sr  <= {sr[6:0], sda_now};
            cnt <= cnt + 4'd1;
          end else if (wr_commit) begin
            sda_oe <= 1'b1;
            st     <= S_WACK;
            if (!pair2) begin
              pair2    <= 1'b1;
              pair_ctl <= sr[7];
              if (sr[7]) {cp_high, test_en, cp_off, drv_off} <= {sr[6], sr[5], sr[4], sr[0]};
              else hi_pend <= sr[6:0];
            end else begin
              pair2 <= 1'b0;
              if (pair_ctl) port_on <= {sr[7], sr[4], sr[2], sr[1], sr[0]};
              else ratio <= {hi_pend, sr};
            end
          end
        S_WACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= S_WR;
          end
        S_RD:
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= S_MACK;
            end else begin
              sda_oe <= ~tx[6];
              tx     <= {tx[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
        S_MACK:
          if (scl_rise) m_ack <= ~sda_now;
          else if (scl_fall) begin
            if (m_ack) begin
              tx     <= status;
              sda_oe <= ~status[7];
              cnt    <= '0;
              st     <= S_RD;
            end else begin
              st <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end

  assert_drive_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == S_AACK || st == S_WACK || st == S_RD));

  assert_ratio_atomic_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio) |-> $past(wr_commit && pair2 && !pair_ctl));

  assert_ports_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_on) |-> $past(wr_commit && pair2 && pair_ctl));

  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe));

  assert_por_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por));

  assert_por_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por) |-> $past(stop_det));
endmodule

// File: tb/sim_tuner_i2c_ctl.sv
module sim_tuner_i2c_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, lock_i = 1'b0;
  logic [1:0] addr_sel = 2'b10;
  logic sda_oe, cp_high, test_en, cp_off, drv_off;
  logic [14:0] ratio;
  logic [4:0] port_on;
  wire sda_bus = sda_m & ~sda_oe;

  tuner_i2c_ctl u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .ratio(ratio), .cp_high(cp_high), .test_en(test_en),
    .cp_off(cp_off), .drv_off(drv_off), .port_on(port_on));

  int vectors = 0, miscompares = 0;
  bit cmp_en = 0, done = 0;
  logic [14:0] e_ratio = '0;
  logic [3:0]  e_ctl = '0;
  logic [4:0]  e_port = '0;
  logic [6:0]  e_hi = '0;
  logic        e_por = 1'b1;
  bit          e_pair2 = 0, e_pctl = 0;

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    chk("R3 ratio", ratio, e_ratio);
    chk("R4 control", {cp_high, test_en, cp_off, drv_off}, e_ctl);
    chk("R5 ports", port_on, e_port);
    chk("R6 sda idle", sda_oe, 0);
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic settle();
    tick(4); cmp_en = 1; tick(4); cmp_en = 0;
  endtask

  task automatic model_byte(logic [7:0] b);
    if (!e_pair2) begin
      e_pair2 = 1; e_pctl = b[7];
      if (b[7]) e_ctl = {b[6], b[5], b[4], b[0]};
      else e_hi = b[6:0];
    end else begin
      e_pair2 = 0;
      if (e_pctl) e_port = {b[7], b[4], b[2], b[1], b[0]};
      else e_ratio = {e_hi, b};
    end
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; tick(8); sda_m = 0; tick(8); scl_m = 0; tick(2);
    e_pair2 = 0;
  endtask

  task automatic i2c_stop();
    tick(2); sda_m = 0; tick(6); scl_m = 1; tick(8); sda_m = 1; tick(8);
    e_pair2 = 0;
  endtask

  task automatic put_bit(logic b);
    tick(2); sda_m = b; tick(6); scl_m = 1; tick(8); scl_m = 0;
  endtask

  task automatic get_bit(output logic b);
    tick(2); sda_m = 1; tick(6); scl_m = 1; tick(4); b = sda_bus; tick(4); scl_m = 0;
  endtask

  task automatic put_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~mack);
  endtask

  task automatic wr_xfer(logic [1:0] sel, logic [7:0] d[$], bit expect_ack);
    logic ack;
    i2c_start();
    put_byte({5'b11000, sel, 1'b0}, ack);
    chk("R1 address ack", ack, expect_ack);
    if (expect_ack)
      foreach (d[i]) begin
        put_byte(d[i], ack);
        chk("R2 data ack", ack, 1);
        model_byte(d[i]);
      end
    i2c_stop();
    settle();
  endtask

  task automatic rd_xfer(int n);
    logic ack; logic [7:0] v; logic b;
    i2c_start();
    put_byte({5'b11000, addr_sel, 1'b1}, ack);
    chk("R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(v, i < n - 1);
      chk("R8 status byte", v, {e_por, lock_i, 6'b0});
    end
    get_bit(b);
    chk("R9 released after nack", b, 1);
    i2c_stop();
    e_por = 0;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog (R6 bus hang) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic ack;
    tick(5); rst_n = 1; tick(2);
    settle();
    chk("R11 sda released", sda_bus, 1);

    wr_xfer(2'b10, '{8'h12, 8'h34}, 1);
    chk("R3 ratio 0x1234", ratio, 15'h1234);
    wr_xfer(2'b10, '{8'hD1, 8'h86}, 1);
    chk("R4 ctrl", {cp_high, test_en, cp_off, drv_off}, 4'b1011);
    chk("R5 ports", port_on, 5'b10110);
    wr_xfer(2'b10, '{8'h7F, 8'hFF, 8'hA0, 8'h13, 8'h01, 8'h00}, 1);
    chk("R6 multi pair ratio", ratio, 15'h0100);
    wr_xfer(2'b01, '{8'h55, 8'h55}, 0);

    addr_sel = 2'b01;
    wr_xfer(2'b01, '{8'h22}, 1);
    chk("R7 half pair ratio", ratio, 15'h0100);
    i2c_start();
    put_byte({5'b11000, 2'b01, 1'b0}, ack);
    put_byte(8'hE0, ack); model_byte(8'hE0);
    for (int i = 0; i < 7; i++) put_bit(1'b1);
    i2c_stop(); settle();
    chk("R7 cut byte ports", port_on, e_port);
    i2c_start();
    put_byte({5'b11000, 2'b01, 1'b0}, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    i2c_stop(); settle();

    lock_i = 1;
    rd_xfer(3);
    lock_i = 0;
    rd_xfer(1);
    wr_xfer(2'b01, '{8'h05, 8'h5A}, 1);
    rd_xfer(2);
    chk("R10 por stays clear", e_por, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule